// File: doc/BRIEF.md
# Indexed block-transfer serial register target

This block is a target-only two-wire serial (I2C) endpoint that answers a single fixed 7-bit address, `1101001`. The address byte on the wire is 0xD2 for a write and 0xD3 for a read. It holds a small file of byte-wide registers. The host reaches the file through indexed block transfers. Every write carries a start-index byte and a length byte ahead of its payload. A read is made by writing a start index and then issuing a repeated START with the read address. The target then returns a length byte followed by consecutive register contents.

The lowest register drives the enable lines of four downstream clock outputs. One register is a fixed identification constant; the remaining bits are general read/write storage. Both bus lines are brought into the system clock domain through a flop synchronizer and edge-detected. START and STOP are honoured at any point of a transfer.

Top module: `i2cbx_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 1101001 (0xD2 write, 0xD3 read) is acknowledged by pulling SDA low during the ninth clock.
- R2: A byte with any other address is not acknowledged. The target then leaves SDA released through every following clock until the next START.
- R3: In a write, the byte after the address is the start index N and the next is the length X, both acknowledged. The following X data bytes are acknowledged and stored in registers N, N+1, … N+X-1.
- R4: Data bytes past the declared length X, including any data byte when X is 0, are not acknowledged and change no register.
- R5: After a read address, the target first sends a length byte equal to the number of registers from N to the last one (0 when N is past the end). It then sends register N, N+1, … for as long as the host acknowledges, and stops driving after a host NACK.
- R6: Any index past the last register reads as 0x00 and ignores writes while still acknowledging them within the length X.
- R7: Register 0 bit k drives `clk_oe_o[k]` for k = 0..3 (1 = enabled). These bits are 1 after reset.
- R8: Register 0 bits 7..4 and registers 1..5 are read/write storage that read 0x00 after reset.
- R9: Register 6 reads 0x01 (revision nibble 0 high, vendor nibble 1 low). Writes to it are acknowledged but leave it unchanged.
- R10: The target changes SDA only while the synchronized SCL is low. It releases SDA in the cycle after any START or STOP.
- R11: `clk_oe_o` changes only while the synchronized SCL is high, that is, on the rising clock of the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 = target pulls SDA low |
| clk_oe_o | output | 4 | Enables for four downstream clock outputs |

## Verification
Both lines pass two synchronizer flops and one edge flop, so the target reacts 3 to 4 system clocks after a bus edge. An acknowledge or read bit appears about four cycles after SCL falls. A register write and the matching `clk_oe_o` change land about four cycles after the SCL rise of the last data bit. The bench host holds each SCL phase for 20 system clocks. It samples SDA in the middle of the high phase and reads `clk_oe_o` only after the STOP has settled, so every sample falls well past these latencies. The scoreboard queues each expected acknowledge and read byte before the bit-level driver clocks it. A monitor compares the two queues in order.

// File: rtl/i2cbx_pkg.sv
package i2cbx_pkg;
   typedef enum logic [2:0] {
      BUS_IDLE,
      BUS_RX,
      BUS_ACK,
      BUS_TX,
      BUS_RACK
   } bus_st_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_INDEX,
      PH_LEN,
      PH_DATA
   } phase_e;
endpackage

// File: rtl/i2cbx_sync.sv
module i2cbx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_prev, sda_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cbx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_prev <= scl_pipe[STAGES-1];
         sda_prev <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2cbx_regs.sv
module i2cbx_regs #(
   parameter int          NUM_REGS = 7,
   parameter int          ID_IDX   = 6,
   parameter logic [7:0]  ID_VALUE = 8'h01,
   parameter int          OE_W     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [7:0]      waddr,
   input  logic [7:0]      wdata,
   input  logic [7:0]      raddr,
   output logic [7:0]      rdata,
   output logic [OE_W-1:0] oe_o
);
   localparam logic [7:0] REG0_RST = 8'((1 << OE_W) - 1);

   logic [7:0] mem [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == ID_IDX) begin : g_const
         assign mem[i] = ID_VALUE;
      end else begin : g_store
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= (i == 0) ? REG0_RST : 8'h00;
            else if (we && waddr == 8'(i))
               q <= wdata;
         end
         assign mem[i] = q;
      end
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NUM_REGS; i++)
         if (raddr == 8'(i)) rdata = mem[i];
   end

   assign oe_o = mem[0][OE_W-1:0];
endmodule

// File: rtl/i2cbx_engine.sv
module i2cbx_engine
   import i2cbx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1101001,
   parameter int         NUM_REGS = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   output logic       we,
   output logic [7:0] waddr,
   output logic [7:0] wdata,
   output logic [7:0] raddr,
   input  logic [7:0] rdata,
   output logic       sda_pull_o
);
   localparam logic [8:0] NREG9 = 9'(NUM_REGS);

   bus_st_e    state;
   phase_e     phase;
   logic [3:0] bit_cnt;
   logic [7:0] rx_sh, tx_sh, ptr, remain;
   logic       rd_mode, first_tx, ack_ok, host_more;

   logic [7:0] byte_w, len_byte, tx_next;
   logic [8:0] len_diff;
   logic       accept, last_rise;

   always_comb begin
      byte_w    = {rx_sh[6:0], sda_s};
      last_rise = (state == BUS_RX) && scl_rise && (bit_cnt == 4'd7);
      unique case (phase)
         PH_ADDR: accept = (byte_w[7:1] == DEV_ADDR);
         PH_DATA: accept = (remain != 8'h00);
         default: accept = 1'b1;
      endcase
      len_diff = NREG9 - {1'b0, ptr};
      len_byte = ({1'b0, ptr} < NREG9) ? len_diff[7:0] : 8'h00;
      tx_next  = first_tx ? len_byte : rdata;
   end

   assign we    = last_rise && (phase == PH_DATA) && accept;
   assign waddr = ptr;
   assign wdata = byte_w;
   assign raddr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= BUS_IDLE;
         phase      <= PH_ADDR;
         bit_cnt    <= 4'd0;
         rx_sh      <= 8'h00;
         tx_sh      <= 8'h00;
         ptr        <= 8'h00;
         remain     <= 8'h00;
         rd_mode    <= 1'b0;
         first_tx   <= 1'b0;
         ack_ok     <= 1'b0;
         host_more  <= 1'b0;
         sda_pull_o <= 1'b0;
      end else if (start_det) begin
         state      <= BUS_RX;
         phase      <= PH_ADDR;
         bit_cnt    <= 4'd0;
         rd_mode    <= 1'b0;
         sda_pull_o <= 1'b0;
      end else if (stop_det) begin
         state      <= BUS_IDLE;
         sda_pull_o <= 1'b0;
      end else begin
         unique case (state)
            BUS_RX: begin
               if (scl_rise) begin
                  rx_sh   <= byte_w;
                  bit_cnt <= bit_cnt + 4'd1;
                  if (last_rise) begin
                     ack_ok <= accept;
                     unique case (phase)
                        PH_ADDR: begin
                           rd_mode  <= byte_w[0];
                           first_tx <= 1'b1;
                           phase    <= PH_INDEX;
                        end
                        PH_INDEX: begin
                           ptr   <= byte_w;
                           phase <= PH_LEN;
                        end
                        PH_LEN: begin
                           remain <= byte_w;
                           phase  <= PH_DATA;
                        end
                        PH_DATA: begin
                           if (accept) begin
                              ptr    <= ptr + 8'd1;
                              remain <= remain - 8'd1;
                           end
                        end
                     endcase
                  end
               end else if (scl_fall && bit_cnt == 4'd8) begin
                  state      <= BUS_ACK;
                  sda_pull_o <= ack_ok;
               end
            end
            BUS_ACK: begin
               if (scl_fall) begin
                  if (!ack_ok) begin
                     state      <= BUS_IDLE;
                     sda_pull_o <= 1'b0;
                  end else if (rd_mode) begin
                     state      <= BUS_TX;
                     tx_sh      <= tx_next;
                     sda_pull_o <= ~tx_next[7];
                     bit_cnt    <= 4'd0;
                     first_tx   <= 1'b0;
                     if (!first_tx) ptr <= ptr + 8'd1;
                  end else begin
                     state      <= BUS_RX;
                     bit_cnt    <= 4'd0;
                     sda_pull_o <= 1'b0;
                  end
               end
            end
            BUS_TX: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (scl_fall) begin
                  if (bit_cnt == 4'd8) begin
                     state      <= BUS_RACK;
                     sda_pull_o <= 1'b0;
                  end else begin
                     tx_sh      <= {tx_sh[6:0], 1'b0};
                     sda_pull_o <= ~tx_sh[6];
                  end
               end
            end
            BUS_RACK: begin
               if (scl_rise) begin
                  host_more <= ~sda_s;
               end else if (scl_fall) begin
                  if (host_more) begin
                     state      <= BUS_TX;
                     tx_sh      <= tx_next;
                     sda_pull_o <= ~tx_next[7];
                     bit_cnt    <= 4'd0;
                     first_tx   <= 1'b0;
                     if (!first_tx) ptr <= ptr + 8'd1;
                  end else begin
                     state      <= BUS_IDLE;
                     sda_pull_o <= 1'b0;
                  end
               end
            end
            default: sda_pull_o <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/i2cbx_slave.sv
module i2cbx_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'b1101001,
   parameter int         NUM_REGS    = 7,
   parameter int         ID_IDX      = 6,
   parameter logic [7:0] ID_VALUE    = 8'h01,
   parameter int         OE_W        = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_pull_o,
   output logic [OE_W-1:0] clk_oe_o
);
   generate
      if (NUM_REGS < 2 || NUM_REGS > 255) begin : g_bad_nregs
         $error("i2cbx_slave: NUM_REGS out of range");
      end
      if (ID_IDX < 1 || ID_IDX >= NUM_REGS) begin : g_bad_id
         $error("i2cbx_slave: ID_IDX must name a register other than 0");
      end
      if (OE_W < 1 || OE_W > 8) begin : g_bad_oe
         $error("i2cbx_slave: OE_W must be 1..8");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic we;
   logic [7:0] waddr, wdata, raddr, rdata;

   i2cbx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2cbx_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata),
      .sda_pull_o(sda_pull_o)
   );

   i2cbx_regs #(.NUM_REGS(NUM_REGS), .ID_IDX(ID_IDX), .ID_VALUE(ID_VALUE),
                .OE_W(OE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata), .oe_o(clk_oe_o)
   );
endmodule

// File: rtl/i2cbx_slave_chk.sv
module i2cbx_slave_chk #(
   parameter int OE_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            scl_s,
   input logic            start_det,
   input logic            stop_det,
   input logic            sda_pull_o,
   input logic [OE_W-1:0] clk_oe_o
);
   // R10
   sda_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_s);

   // R10
   release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull_o);

   // R10
   release_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_pull_o);

   // R11
   oe_only_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_oe_o) |-> scl_s);

   // R7
   oe_reset_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (clk_oe_o == '1));
endmodule

bind i2cbx_slave i2cbx_slave_chk #(.OE_W(OE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_pull_o(sda_pull_o), .clk_oe_o(clk_oe_o)
);

// File: tb/test_i2cbx_slave.sv
module test_i2cbx_slave;
   localparam int HALF = 20;
   localparam int QTR  = 5;
   localparam logic [7:0] AW = 8'hD2;
   localparam logic [7:0] AR = 8'hD3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic m_pull = 1'b0;
   logic s_pull;
   logic [3:0] oe;
   wire sda_line = ~(m_pull | s_pull);

   always #2.5 clk = ~clk;

   i2cbx_slave i_i2cbx_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pull_o(s_pull), .clk_oe_o(oe)
   );

   typedef struct { string req; logic [7:0] val; } item_t;
   item_t      exp_q[$];
   logic [7:0] obs_q[$];
   int n_cmp = 0, n_bad = 0;
   bit reported = 0;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // monitor: pops expected and observed items in order
   always @(negedge clk) begin
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
         item_t e;
         logic [7:0] o;
         e = exp_q.pop_front();
         o = obs_q.pop_front();
         check(e.req, o, e.val);
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_pull = 1'b0; wait_clk(QTR);
      scl_m = 1'b1;  wait_clk(HALF);
      m_pull = 1'b1; wait_clk(HALF);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wait_clk(QTR); m_pull = 1'b1; wait_clk(HALF - QTR);
      scl_m = 1'b1;  wait_clk(HALF);
      m_pull = 1'b0; wait_clk(HALF * 2);
   endtask

   task automatic put_bit(input logic b);
      wait_clk(QTR); m_pull = ~b; wait_clk(HALF - QTR);
      scl_m = 1'b1; wait_clk(HALF);
      scl_m = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      wait_clk(QTR); m_pull = 1'b0; wait_clk(HALF - QTR);
      scl_m = 1'b1; wait_clk(HALF / 2);
      b = sda_line; wait_clk(HALF / 2);
      scl_m = 1'b0;
   endtask

   // driver: host sends a byte; expected ack (0 = ACK) is queued first
   task automatic send(input logic [7:0] d, input logic exp_nack, input string req);
      logic a;
      exp_q.push_back('{req, {7'd0, exp_nack}});
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(a);
      obs_q.push_back({7'd0, a});
   endtask

   // driver: host reads a byte, then ACKs or NACKs it
   task automatic recv(input logic [7:0] exp, input logic last, input string req);
      logic [7:0] d;
      exp_q.push_back('{req, exp});
      for (int i = 7; i >= 0; i--) get_bit(d[i]);
      obs_q.push_back(d);
      put_bit(last);
   endtask

   task automatic set_index(input logic [7:0] n);
      bus_start();
      send(AW, 1'b0, "R1 write address");
      send(n, 1'b0, "R3 index byte");
   endtask

   task automatic rd_begin(input logic [7:0] n, input logic [7:0] len);
      set_index(n);
      bus_start();
      send(AR, 1'b0, "R1 read address");
      recv(len, 1'b0, "R5 length byte");
   endtask

   initial begin
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(5);
      check("R7 reset enables", {4'd0, oe}, 8'h0F);
      check("R10 idle release", {7'd0, s_pull}, 8'h00);

      // read the whole file after reset
      rd_begin(8'd0, 8'd7);
      recv(8'h0F, 1'b0, "R7/R8 reg0 reset");
      for (int i = 1; i <= 5; i++) recv(8'h00, 1'b0, "R8 reserved reset");
      recv(8'h01, 1'b0, "R9 id value");
      recv(8'h00, 1'b1, "R6 beyond end");
      bus_stop();

      // block write of three bytes, fourth one refused
      set_index(8'd0);
      send(8'd3, 1'b0, "R3 length byte");
      send(8'hA5, 1'b0, "R3 data 0");
      send(8'h11, 1'b0, "R3 data 1");
      send(8'h22, 1'b0, "R3 data 2");
      send(8'h33, 1'b1, "R4 excess byte nack");
      bus_stop();
      check("R7 enables follow reg0", {4'd0, oe}, 8'h05);

      rd_begin(8'd0, 8'd7);
      recv(8'hA5, 1'b0, "R8 reg0 upper nibble");
      recv(8'h11, 1'b0, "R3 reg1");
      recv(8'h22, 1'b0, "R3 reg2");
      recv(8'h00, 1'b0, "R4 reg3 untouched");
      recv(8'h00, 1'b0, "R8 reg4");
      recv(8'h00, 1'b0, "R8 reg5");
      recv(8'h01, 1'b1, "R9 id value");
      bus_stop();

      // writes to id register and past the end: acked, ignored
      set_index(8'd6);
      send(8'd2, 1'b0, "R3 length byte");
      send(8'hFF, 1'b0, "R9 id write acked");
      send(8'h77, 1'b0, "R6 past-end write acked");
      bus_stop();
      rd_begin(8'd5, 8'd2);
      recv(8'h00, 1'b0, "R8 reg5");
      recv(8'h01, 1'b0, "R9 id unchanged");
      recv(8'h00, 1'b1, "R6 past end reads zero");
      bus_stop();

      // zero length: data refused
      set_index(8'd2);
      send(8'd0, 1'b0, "R3 length byte");
      send(8'h55, 1'b1, "R4 zero length nack");
      bus_stop();
      rd_begin(8'd2, 8'd5);
      recv(8'h22, 1'b1, "R4 reg2 kept");
      bus_stop();

      // index far past the end
      rd_begin(8'd200, 8'd0);
      recv(8'h00, 1'b1, "R6 far index zero");
      bus_stop();

      // foreign address: nack, line left released
      bus_start();
      send(8'hA0, 1'b1, "R2 foreign address nack");
      recv(8'hFF, 1'b1, "R2 line released");
      bus_stop();

      // disable all outputs
      set_index(8'd0);
      send(8'd1, 1'b0, "R3 length byte");
      send(8'h00, 1'b0, "R3 data");
      bus_stop();
      check("R7 all disabled", {4'd0, oe}, 8'h00);
      check("R10 released after stop", {7'd0, s_pull}, 8'h00);

      wait_clk(10);
      if (exp_q.size() != 0) check("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
      if (!reported) begin
         reported = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!reported) begin
         reported = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
      $finish;
   end
endmodule